// File: doc/BRIEF.md
# Mask-Centrifuge Global Address Translator

This block turns a remote memory request into a network routing tag and a global virtual address. A request names one of the communication registers (an 8-bit pointer) and supplies a 50-bit address index. Each register holds three pieces of translation state, loaded beforehand through a setup port: a centrifuge mask, a base offset and a segment descriptor. A shared table maps logical PE numbers to physical routing tags and is loaded through the same port.

The mask does not pick the PE number from a fixed field. Index bits under a 1 in the mask are gathered, lowest first, into a virtual PE number. Index bits under a 0 are packed, lowest first, into a compact virtual address. The offset is added to that address. The sum splits into a virtual segment number and a 32-bit segment offset. The segment descriptor checks the virtual segment and supplies a global segment and a base PE. The base PE plus the virtual PE gives a logical PE, which selects the routing tag. The result carries either a tag and a global address, or a fault flag.

The translation runs as a five-register pipeline. Inputs and outputs use valid/ready handshakes, and the block accepts one request per cycle.

Top module: `gat_xlate`

## Requirements
- R1: Index bits whose mask bit is 1 go, in ascending bit order, into the virtual PE number; only its low 11 bits are kept. Index bits whose mask bit is 0 go, in ascending order, into the virtual address, starting at bit 0.
- R2: The virtual address plus the register's offset, taken modulo 2^50, gives the virtual segment (sum bits 49..32) and the segment offset (sum bits 31..0).
- R3: A descriptor is a hit when its valid bit is 1 and its virtual-segment field equals the virtual segment. On a miss, out_fault_seg is 1, out_fault_pe is 0, and out_tag and out_gva are both zero.
- R4: On a hit, the logical PE is the base PE plus the virtual PE, added without wrap in 12 bits. If the logical PE is below 64, out_tag is the table entry it selects. Otherwise out_fault_pe is 1, out_fault_seg is 0, and out_tag and out_gva are zero.
- R5: A result with no fault has out_gva = {global segment (6 bits), segment offset (32 bits)}.
- R6: setup_sel selects the target: 0 = mask, 1 = offset, 2 = segment descriptor, 3 = table entry. A descriptor is packed as follows: virtual segment in bits 17..0, global segment in bits 23..18, base PE in bits 34..24, valid in bit 35. A table write uses bits 15..0 and is dropped when setup_addr is 64 or more. A register write on a clock edge affects requests accepted on later edges. It does not affect a request accepted on the same edge.
- R7: Results leave in acceptance order, with exactly one result per accepted request. While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low.
- R8: After reset, out_valid is 0, in_ready is 1, every descriptor is invalid and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_ptr | input | 8 | Register pointer selecting the translation state |
| in_idx | input | 50 | Address index to centrifuge |
| setup_valid | input | 1 | Setup write strobe |
| setup_sel | input | 2 | Setup target: 0 mask, 1 offset, 2 descriptor, 3 table |
| setup_addr | input | 8 | Register pointer, or table index |
| setup_data | input | 50 | Write data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_tag | output | 16 | Physical routing tag, zero on fault |
| out_gva | output | 38 | Global segment and segment offset, zero on fault |
| out_fault_seg | output | 1 | Segment not mapped |
| out_fault_pe | output | 1 | Logical PE outside the table |

## Verification
The assertions assume that out_ready is the only thing that stalls the pipeline. They also assume that table writes never change an entry while a request still needs it. Without the second condition, an in-flight result could pick up either tag, and the in-order hold properties would still pass while the value was undefined. The stimulus writes the table only before traffic starts. Random setup traffic is limited to register masks, which are captured when a request is accepted. Request indices keep their upper bits clear, and offsets are chosen so that most requests hit a descriptor, while a minority miss or overrun the table.

// File: rtl/gat_pkg.sv
package gat_pkg;

    localparam int GAT_IDX_W  = 50;
    localparam int GAT_PTR_W  = 8;
    localparam int GAT_SOFF_W = 32;
    localparam int GAT_GSEG_W = 6;
    localparam int GAT_LPE_W  = 11;
    localparam int GAT_TAG_W  = 16;
    localparam int GAT_PET_N  = 64;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_OFF  = 2'd1,
        SEL_SEG  = 2'd2,
        SEL_PET  = 2'd3
    } setup_sel_e;

endpackage

// File: rtl/gat_centrifuge.sv
module gat_centrifuge #(
    parameter int IDX_W = 50,
    parameter int VPE_W = 11
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] mask,
    output logic [VPE_W-1:0] vpe,
    output logic [IDX_W-1:0] va
);

    // Ones under the mask gather into vpe, zeros pack into va, both lowest first.
    always_comb begin
        int np;
        int na;
        vpe = '0;
        va  = '0;
        np  = 0;
        na  = 0;
        for (int i = 0; i < IDX_W; i++) begin
            if (mask[i]) begin
                if (np < VPE_W) vpe[np] = idx[i];
                np = np + 1;
            end else begin
                va[na] = idx[i];
                na = na + 1;
            end
        end
    end

endmodule

// File: rtl/gat_ereg_file.sv
module gat_ereg_file
    import gat_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int IDX_W = 50,
    parameter int SD_W  = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [IDX_W-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [IDX_W-1:0] rd_mask,
    output logic [IDX_W-1:0] rd_off,
    output logic [SD_W-1:0]  rd_sd
);

    localparam int NREG = 2 ** PTR_W;

    typedef struct packed {
        logic [IDX_W-1:0] mask;
        logic [IDX_W-1:0] off;
        logic [SD_W-1:0]  sd;
    } ent_t;

    ent_t tbl_q [NREG];
    ent_t tbl_d [NREG];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            case (setup_sel_e'(wr_sel))
                SEL_MASK: tbl_d[wr_ptr].mask = wr_data;
                SEL_OFF:  tbl_d[wr_ptr].off  = wr_data;
                SEL_SEG:  tbl_d[wr_ptr].sd   = wr_data[SD_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) tbl_q[r] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_mask = tbl_q[rd_ptr].mask;
    assign rd_off  = tbl_q[rd_ptr].off;
    assign rd_sd   = tbl_q[rd_ptr].sd;

endmodule

// File: rtl/gat_pe_table.sv
module gat_pe_table #(
    parameter int PET_N = 64,
    parameter int TAG_W = 16,
    localparam int PET_AW = $clog2(PET_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PET_AW-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PET_AW-1:0] rd_idx,
    output logic [TAG_W-1:0]  rd_tag
);

    logic [TAG_W-1:0] tag_q [PET_N];
    logic [TAG_W-1:0] tag_d [PET_N];

    always_comb begin
        tag_d = tag_q;
        if (wr_en) tag_d[wr_idx] = wr_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < PET_N; e++) tag_q[e] <= '0;
        end else begin
            tag_q <= tag_d;
        end
    end

    assign rd_tag = tag_q[rd_idx];

endmodule

// File: rtl/gat_xlate.sv
module gat_xlate
    import gat_pkg::*;
#(
    parameter int IDX_W  = GAT_IDX_W,
    parameter int PTR_W  = GAT_PTR_W,
    parameter int SOFF_W = GAT_SOFF_W,
    parameter int GSEG_W = GAT_GSEG_W,
    parameter int LPE_W  = GAT_LPE_W,
    parameter int TAG_W  = GAT_TAG_W,
    parameter int PET_N  = GAT_PET_N
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PTR_W-1:0]         in_ptr,
    input  logic [IDX_W-1:0]         in_idx,
    input  logic                     setup_valid,
    input  logic [1:0]               setup_sel,
    input  logic [PTR_W-1:0]         setup_addr,
    input  logic [IDX_W-1:0]         setup_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [TAG_W-1:0]         out_tag,
    output logic [GSEG_W+SOFF_W-1:0] out_gva,
    output logic                     out_fault_seg,
    output logic                     out_fault_pe
);

    localparam int VSEG_W   = IDX_W - SOFF_W;
    localparam int SD_GSEG  = VSEG_W;
    localparam int SD_BASE  = VSEG_W + GSEG_W;
    localparam int SD_VALID = VSEG_W + GSEG_W + LPE_W;
    localparam int SD_W     = SD_VALID + 1;
    localparam int GVA_W    = GSEG_W + SOFF_W;
    localparam int LPE_SW   = LPE_W + 1;
    localparam int PET_AW   = $clog2(PET_N);

    typedef struct packed {
        // stage 0: captured request and register snapshot
        logic              s0_v;
        logic [IDX_W-1:0]  s0_idx;
        logic [IDX_W-1:0]  s0_mask;
        logic [IDX_W-1:0]  s0_off;
        logic [SD_W-1:0]   s0_sd;
        // stage 1: centrifuged
        logic              s1_v;
        logic [LPE_W-1:0]  s1_vpe;
        logic [IDX_W-1:0]  s1_va;
        logic [IDX_W-1:0]  s1_off;
        logic [SD_W-1:0]   s1_sd;
        // stage 2: offset added
        logic              s2_v;
        logic [VSEG_W-1:0] s2_vseg;
        logic [SOFF_W-1:0] s2_soff;
        logic [LPE_W-1:0]  s2_vpe;
        logic [SD_W-1:0]   s2_sd;
        // stage 3: segment translated, PE relocated
        logic              s3_v;
        logic              s3_fseg;
        logic [GSEG_W-1:0] s3_gseg;
        logic [SOFF_W-1:0] s3_soff;
        logic [LPE_SW-1:0] s3_lpe;
        // output stage: table looked up
        logic              o_v;
        logic [TAG_W-1:0]  o_tag;
        logic [GVA_W-1:0]  o_gva;
        logic              o_fseg;
        logic              o_fpe;
    } pipe_t;

    pipe_t p_d, p_q;

    logic              stall;
    logic [IDX_W-1:0]  rd_mask, rd_off;
    logic [SD_W-1:0]   rd_sd;
    logic [LPE_W-1:0]  cf_vpe;
    logic [IDX_W-1:0]  cf_va;
    logic [TAG_W-1:0]  pet_tag;
    logic              pet_wr;
    logic [IDX_W-1:0]  sum;
    logic              seg_hit;
    logic              pe_over;

    assign stall    = p_q.o_v && !out_ready;
    assign in_ready = !stall;
    assign pet_wr   = setup_valid && (setup_sel_e'(setup_sel) == SEL_PET)
                      && ({1'b0, setup_addr} < (PTR_W+1)'(PET_N));

    gat_ereg_file #(
        .PTR_W (PTR_W),
        .IDX_W (IDX_W),
        .SD_W  (SD_W)
    ) u_eregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (setup_valid),
        .wr_sel  (setup_sel),
        .wr_ptr  (setup_addr),
        .wr_data (setup_data),
        .rd_ptr  (in_ptr),
        .rd_mask (rd_mask),
        .rd_off  (rd_off),
        .rd_sd   (rd_sd)
    );

    gat_centrifuge #(
        .IDX_W (IDX_W),
        .VPE_W (LPE_W)
    ) u_cfg (
        .idx  (p_q.s0_idx),
        .mask (p_q.s0_mask),
        .vpe  (cf_vpe),
        .va   (cf_va)
    );

    gat_pe_table #(
        .PET_N (PET_N),
        .TAG_W (TAG_W)
    ) u_pet (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pet_wr),
        .wr_idx (setup_addr[PET_AW-1:0]),
        .wr_tag (setup_data[TAG_W-1:0]),
        .rd_idx (p_q.s3_lpe[PET_AW-1:0]),
        .rd_tag (pet_tag)
    );

    always_comb begin
        p_d     = p_q;
        sum     = p_q.s1_va + p_q.s1_off;
        seg_hit = p_q.s2_sd[SD_VALID] && (p_q.s2_sd[VSEG_W-1:0] == p_q.s2_vseg);
        pe_over = !p_q.s3_fseg && (p_q.s3_lpe >= LPE_SW'(PET_N));
        if (!stall) begin
            p_d.s0_v    = in_valid;
            p_d.s0_idx  = in_idx;
            p_d.s0_mask = rd_mask;
            p_d.s0_off  = rd_off;
            p_d.s0_sd   = rd_sd;

            p_d.s1_v    = p_q.s0_v;
            p_d.s1_vpe  = cf_vpe;
            p_d.s1_va   = cf_va;
            p_d.s1_off  = p_q.s0_off;
            p_d.s1_sd   = p_q.s0_sd;

            p_d.s2_v    = p_q.s1_v;
            p_d.s2_vseg = sum[IDX_W-1:SOFF_W];
            p_d.s2_soff = sum[SOFF_W-1:0];
            p_d.s2_vpe  = p_q.s1_vpe;
            p_d.s2_sd   = p_q.s1_sd;

            p_d.s3_v    = p_q.s2_v;
            p_d.s3_fseg = !seg_hit;
            p_d.s3_gseg = p_q.s2_sd[SD_GSEG +: GSEG_W];
            p_d.s3_soff = p_q.s2_soff;
            p_d.s3_lpe  = {1'b0, p_q.s2_sd[SD_BASE +: LPE_W]} + {1'b0, p_q.s2_vpe};

            p_d.o_v     = p_q.s3_v;
            p_d.o_fseg  = p_q.s3_fseg;
            p_d.o_fpe   = pe_over;
            if (p_q.s3_fseg || pe_over) begin
                p_d.o_tag = '0;
                p_d.o_gva = '0;
            end else begin
                p_d.o_tag = pet_tag;
                p_d.o_gva = {p_q.s3_gseg, p_q.s3_soff};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid     = p_q.o_v;
    assign out_tag       = p_q.o_tag;
    assign out_gva       = p_q.o_gva;
    assign out_fault_seg = p_q.o_fseg;
    assign out_fault_pe  = p_q.o_fpe;

endmodule

// File: rtl/gat_xlate_chk.sv
module gat_xlate_chk #(
    parameter int TAG_W = 16,
    parameter int GVA_W = 38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TAG_W-1:0] out_tag,
    input logic [GVA_W-1:0] out_gva,
    input logic             out_fault_seg,
    input logic             out_fault_pe
);

    localparam int DEPTH = 5;

    logic [3:0] inflight_q;
    logic       in_fire, out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + 4'(in_fire) - 4'(out_fire);
    end

    p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_fault_seg && out_fault_pe));

    p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_fault_seg || out_fault_pe) |-> (out_tag == '0) && (out_gva == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_gva)
                                    && $stable(out_fault_seg) && $stable(out_fault_pe));

    p_backpress_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    p_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 4'(DEPTH));

    p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire |-> inflight_q != '0);

    p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

endmodule

bind gat_xlate gat_xlate_chk #(
    .TAG_W (TAG_W),
    .GVA_W (GVA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_tag       (out_tag),
    .out_gva       (out_gva),
    .out_fault_seg (out_fault_seg),
    .out_fault_pe  (out_fault_pe)
);

// File: tb/sim_gat_xlate.sv
module sim_gat_xlate;
    import gat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_ptr = '0;
    logic [49:0] in_idx = '0;
    logic        setup_valid = 1'b0;
    logic [1:0]  setup_sel = '0;
    logic [7:0]  setup_addr = '0;
    logic [49:0] setup_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_tag;
    logic [37:0] out_gva;
    logic        out_fault_seg, out_fault_pe;

    gat_xlate u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ptr(in_ptr), .in_idx(in_idx), .setup_valid(setup_valid),
        .setup_sel(setup_sel), .setup_addr(setup_addr), .setup_data(setup_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_gva(out_gva), .out_fault_seg(out_fault_seg), .out_fault_pe(out_fault_pe)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit          fseg;
        bit          fpe;
        logic [15:0] tag;
        logic [37:0] gva;
        string       lbl;
    } exp_t;

    logic [49:0] mask_m [256];
    logic [49:0] off_m  [256];
    logic [49:0] seg_m  [256];
    logic [15:0] pet_m  [64];

    exp_t  q[$];
    exp_t  dir_exp;
    bit    dir_en = 1'b0;
    string cur_lbl = "";
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Expected result from the requirements (R1..R5).
    function automatic exp_t model(input int ptr, input logic [49:0] idx, input string lbl);
        exp_t        e;
        logic [49:0] m, va, sum, sd;
        logic [10:0] vpe;
        int          ka, kp, lpe;
        m = mask_m[ptr]; va = '0; vpe = '0; ka = 0; kp = 0;
        for (int b = 0; b < 50; b++) begin
            if (m[b] == 1'b0) begin va[ka] = idx[b]; ka++; end
            else begin if (kp < 11) vpe[kp] = idx[b]; kp++; end
        end
        sum = va + off_m[ptr];
        sd  = seg_m[ptr];
        e.lbl = lbl; e.fseg = 0; e.fpe = 0; e.tag = '0; e.gva = '0;
        if (sd[35] != 1'b1 || sd[17:0] != sum[49:32]) begin
            e.fseg = 1;
        end else begin
            lpe = int'(sd[34:24]) + int'(vpe);
            if (lpe >= 64) e.fpe = 1;
            else begin
                e.tag = pet_m[lpe];
                e.gva = {sd[23:18], sum[31:0]};
            end
        end
        return e;
    endfunction

    function automatic logic [49:0] rand_mask();
        logic [49:0] m = '0;
        repeat (6) m[$urandom % 30] = 1'b1;
        return m;
    endfunction

    function automatic logic [49:0] sdesc(input bit v, input int vseg, input int gseg, input int base);
        return {14'b0, v, 11'(base), 6'(gseg), 18'(vseg)};
    endfunction

    // Handshakes are judged 5 ns after the drive edge, ahead of the sampling edge.
    task automatic eval_edge();
        exp_t e;
        if (in_valid && in_ready) begin
            if (dir_en) q.push_back(dir_exp);
            else        q.push_back(model(int'(in_ptr), in_idx, cur_lbl));
        end
        if (out_valid && !out_ready)
            chk(in_ready == 1'b0, "R7 in_ready low under back-pressure", 64'(in_ready), 64'd0);
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "R7 result with no accepted request", 64'd1, 64'd0);
            end else begin
                e = q.pop_front();
                chk(out_fault_seg == e.fseg, {"R3 fault_seg ", e.lbl}, 64'(out_fault_seg), 64'(e.fseg));
                chk(out_fault_pe == e.fpe, {"R4 fault_pe ", e.lbl}, 64'(out_fault_pe), 64'(e.fpe));
                chk(out_tag == e.tag, {"R4 tag ", e.lbl}, 64'(out_tag), 64'(e.tag));
                chk(out_gva == e.gva, {"R1 R2 R5 gva ", e.lbl}, 64'(out_gva), 64'(e.gva));
            end
        end
        if (setup_valid) begin
            case (setup_sel)
                2'd0: mask_m[setup_addr] = setup_data;
                2'd1: off_m[setup_addr]  = setup_data;
                2'd2: seg_m[setup_addr]  = setup_data;
                default: if (setup_addr < 64) pet_m[setup_addr] = setup_data[15:0];
            endcase
        end
    endtask

    task automatic cycle();
        #5;
        eval_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input int addr, input logic [49:0] data);
        setup_valid = 1'b1; setup_sel = sel; setup_addr = 8'(addr); setup_data = data;
        in_valid = 1'b0;
        cycle();
        setup_valid = 1'b0;
    endtask

    task automatic req(input int ptr, input logic [49:0] idx, input string lbl);
        in_valid = 1'b1; in_ptr = 8'(ptr); in_idx = idx; cur_lbl = lbl; out_ready = 1'b1;
        cycle();
        in_valid = 1'b0;
    endtask

    task automatic dreq(input int ptr, input logic [49:0] idx, input bit fs, input bit fp,
                        input logic [15:0] tg, input logic [37:0] ga, input string lbl);
        dir_exp.fseg = fs; dir_exp.fpe = fp; dir_exp.tag = tg; dir_exp.gva = ga; dir_exp.lbl = lbl;
        dir_en = 1'b1;
        req(ptr, idx, lbl);
        dir_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7541));
        for (int r = 0; r < 256; r++) begin mask_m[r] = '0; off_m[r] = '0; seg_m[r] = '0; end
        for (int t = 0; t < 64; t++) pet_m[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        chk(out_valid == 1'b0, "R8 out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R8 in_ready after reset", 64'(in_ready), 64'd1);
        @(negedge clk);

        // R8: an untouched register has an invalid descriptor
        req(0, 50'h123, "R8 reset descriptor");

        // Table contents, then eight working registers
        for (int t = 0; t < 64; t++) wr(2'd3, t, 50'(16'h8000 | 16'($urandom % 16'h7fff)));
        wr(2'd3, 100, 50'hBEEF); // out of range, dropped (R6)
        for (int r = 0; r < 8; r++) begin
            wr(2'd0, r, rand_mask());
            wr(2'd1, r, (r == 5) ? ((50'(r + 3) << 32) | 50'hFFFF_FF00) : (50'(r + 3) << 32));
            if (r == 6)      wr(2'd2, r, sdesc(1, r + 4, r * 5 + 1, r * 8));
            else if (r == 7) wr(2'd2, r, sdesc(0, r + 3, r * 5 + 1, r * 8));
            else             wr(2'd2, r, sdesc(1, r + 3, r * 5 + 1, r * 8));
        end

        // R1: mask 1010b, index 11011b -> vpe 3, va 5
        wr(2'd0, 10, 50'hA);
        wr(2'd1, 10, 50'(5) << 32);
        wr(2'd2, 10, sdesc(1, 5, 9, 0));
        dreq(10, 50'h1B, 0, 0, pet_m[3], {6'd9, 32'd5}, "R1 directed centrifuge");

        // R4 boundary: logical PE 63 valid, 64 faults
        wr(2'd0, 12, '0); wr(2'd1, 12, 50'(7) << 32); wr(2'd2, 12, sdesc(1, 7, 2, 63));
        dreq(12, 50'h10, 0, 0, pet_m[63], {6'd2, 32'h10}, "R4 logical PE 63");
        wr(2'd2, 12, sdesc(1, 7, 2, 64));
        dreq(12, 50'h10, 0, 1, '0, '0, "R4 logical PE 64");

        // R2: carry from the offset field into the segment number
        wr(2'd0, 14, '0); wr(2'd1, 14, (50'(2) << 32) | 50'hFFFF_FFFF); wr(2'd2, 14, sdesc(1, 3, 33, 4));
        dreq(14, 50'h1, 0, 0, pet_m[4], {6'd33, 32'd0}, "R2 offset carry");

        // R3: valid descriptor, wrong segment
        dreq(14, 50'h2_0000_0000, 1, 0, '0, '0, "R3 segment mismatch");

        // R6: write and request on the same edge see the old mask; the next sees the new one
        wr(2'd0, 11, 50'h1); wr(2'd1, 11, 50'(1) << 32); wr(2'd2, 11, sdesc(1, 1, 3, 0));
        setup_valid = 1'b1; setup_sel = 2'd0; setup_addr = 8'd11; setup_data = 50'h2;
        dreq(11, 50'h3, 0, 0, pet_m[1], {6'd3, 32'd1}, "R6 same-edge write unseen");
        setup_valid = 1'b0;
        dreq(11, 50'h3, 0, 0, pet_m[1], {6'd3, 32'd1}, "R6 following request uses new mask");
        dreq(11, 50'h2, 0, 0, pet_m[1], {6'd3, 32'd0}, "R6 new mask selects bit 1");

        // Random traffic with back-pressure and mask rewrites (R7, R6)
        for (int n = 0; n < 4000; n++) begin
            int p;
            p = $urandom % 9;
            out_ready = ($urandom % 4) != 0;
            in_valid  = ($urandom % 3) != 0;
            in_ptr    = (p == 8) ? 8'd200 : 8'(p);
            in_idx    = {20'b0, 30'($urandom)};
            cur_lbl   = "R7 random stream";
            setup_valid = ($urandom % 16) == 0;
            setup_sel   = 2'd0;
            setup_addr  = 8'($urandom % 6);
            setup_data  = rand_mask();
            cycle();
        end
        setup_valid = 1'b0;
        in_valid    = 1'b0;
        out_ready   = 1'b1;
        repeat (12) cycle();
        chk(q.size() == 0, "R7 one result per accepted request", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule